// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM that holds 32768 bytes. The host raises a request with a direction bit, an address and write data. The block runs one memory cycle on the chip-enable, output-enable and write-enable strobes, all of them active low. It then returns a one-cycle acknowledge, and on a read the data comes back with it. The memory data bus is split into an output value, an input value and a driver enable, so that a tri-state pad outside the block can join them.

Every interval is a parameter given in picoseconds, and the clock period is one of those parameters. The block turns each interval into a whole number of cycles: the time divided by the period, rounded up, and never less than one. The default clock is 10 ns. With that clock a read holds its strobes for 2 cycles. A write takes 1 setup cycle, 1 release cycle, 1 drive cycle and 1 hold cycle.

The sequencing keeps the address steady for as long as write enable is low, and every write ends on the rising edge of write enable. When the next access goes the other way, the block inserts quiet cycles first, so the controller and the memory never drive the bus at the same time. Between accesses chip enable is high, which leaves the memory in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are mem_ce_n=1, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and host_ack=0.
- R2: With no access in progress, mem_ce_n=1, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R3: A read (host_wr=0) holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for ceil(T_ACCESS_PS/CLK_PS) cycles, which is 2 by default. On the edge that ends those cycles, mem_dq_in is stored in host_rdata.
- R4: A write (host_wr=1) holds mem_oe_n=1 throughout. It first spends one cycle with mem_ce_n=0 and mem_we_n=1. It then holds mem_we_n=0 for ceil(T_RELEASE_PS/CLK_PS) cycles plus max(ceil(T_DSETUP_PS/CLK_PS), ceil(T_WPULSE_PS/CLK_PS) minus the release count) cycles.
- R5: During a write, mem_dq_oe stays 0 for the release cycles after mem_we_n falls. It is then 1 with mem_dq_out equal to the write data, and it stays 1 for one cycle after mem_we_n rises.
- R6: mem_addr shows the captured request address whenever mem_ce_n=0, and it does not change while mem_we_n=0.
- R7: When an access goes the opposite way from the previous one, ceil(T_TURN_PS/CLK_PS) cycles with all strobes inactive (1 by default) come before its first active strobe.
- R8: mem_dq_oe is never 1 while mem_oe_n=0 or while mem_ce_n=1.
- R9: A request is taken only when no access is in progress. While an access is in progress, host_req and the other host inputs have no effect on the memory pins.
- R10: host_ack is 1 for exactly one cycle per access, in the cycle after the last active strobe cycle, with mem_ce_n=1. On a read, host_rdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, sampled when idle |
| host_wr | input | 1 | 1 selects a write, 0 a read |
| host_addr | input | 15 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read result, valid with host_ack |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Data to the pad |
| mem_dq_in | input | 8 | Data from the pad |
| mem_dq_oe | output | 1 | Pad driver enable |

## Verification
The hardest case to reach is a request that changes direction while the host keeps host_req high and alters its address, data and direction in the middle of an access. In that case the turnaround cycles and the no-effect rule for busy requests are both in play at once. The stimulus reaches it in three ways: it alternates reads and writes in a fixed order, it rewrites every host input two cycles into an access, and it runs a random mix over a small set of addresses with gaps of zero to three cycles. The cycle-level model predicts every strobe, the driver enable, the address and the read result, and a byte store in the bench plays the part of the memory.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WSETUP, ST_WREL, ST_WDRIVE, ST_WHOLD, ST_RACC
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_set_t;

  // Whole cycles covering t_ps at period p_ps, never fewer than one.
  function automatic int cyc_of(input int t_ps, input int p_ps);
    int c;
    c = (t_ps + p_ps - 1) / p_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_set_t pins_of(input seq_state_t s);
    pin_set_t p;
    unique case (s)
      ST_WSETUP: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      ST_WREL:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b0};
      ST_WDRIVE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      ST_WHOLD:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      ST_RACC:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      default:   p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq_capture.sv
module sram_seq_capture #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              cap_wr,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              seen_any
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_wr    <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
      seen_any  <= 1'b0;
    end else if (take) begin
      cap_wr    <= in_wr;
      cap_addr  <= in_addr;
      cap_wdata <= in_wdata;
      seen_any  <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t st_nx,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       dq_oe
);
  pin_set_t nxt;

  always_comb nxt = pins_of(st_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= nxt.ce_n;
      oe_n  <= nxt.oe_n;
      we_n  <= nxt.we_n;
      dq_oe <= nxt.dq_oe;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int CLK_PS       = 10000,
  parameter int T_ACCESS_PS  = 12000,
  parameter int T_WPULSE_PS  = 10000,
  parameter int T_DSETUP_PS  = 6000,
  parameter int T_RELEASE_PS = 6000,
  parameter int T_TURN_PS    = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int RD_CYC  = cyc_of(T_ACCESS_PS, CLK_PS);
  localparam int WP_CYC  = cyc_of(T_WPULSE_PS, CLK_PS);
  localparam int DS_CYC  = cyc_of(T_DSETUP_PS, CLK_PS);
  localparam int REL_CYC = cyc_of(T_RELEASE_PS, CLK_PS);
  localparam int TA_CYC  = cyc_of(T_TURN_PS, CLK_PS);
  localparam int DRV_CYC = imax(DS_CYC, WP_CYC - REL_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, DRV_CYC), imax(REL_CYC, TA_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC));

  seq_state_t       st, st_nx;
  logic             take, ld, done, fin_rd, fin_wr;
  logic [CNT_W-1:0] ld_val;
  logic             cap_wr, seen_any;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .done(done)
  );

  sram_seq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .take(take),
    .in_wr(host_wr), .in_addr(host_addr), .in_wdata(host_wdata),
    .cap_wr(cap_wr), .cap_addr(mem_addr), .cap_wdata(mem_dq_out),
    .seen_any(seen_any)
  );

  sram_seq_pins u_pins (
    .clk(clk), .rst(rst), .st_nx(st_nx),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  always_comb begin
    st_nx  = st;
    ld     = 1'b0;
    ld_val = '0;
    take   = 1'b0;
    fin_rd = 1'b0;
    fin_wr = 1'b0;
    unique case (st)
      ST_IDLE: if (host_req) begin
        take = 1'b1;
        ld   = 1'b1;
        if (seen_any && (host_wr != cap_wr)) begin
          st_nx  = ST_TURN;
          ld_val = CNT_W'(TA_CYC - 1);
        end else if (host_wr) begin
          st_nx  = ST_WSETUP;
        end else begin
          st_nx  = ST_RACC;
          ld_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_TURN: if (done) begin
        ld = 1'b1;
        if (cap_wr) begin
          st_nx = ST_WSETUP;
        end else begin
          st_nx  = ST_RACC;
          ld_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSETUP: if (done) begin
        st_nx  = ST_WREL;
        ld     = 1'b1;
        ld_val = CNT_W'(REL_CYC - 1);
      end
      ST_WREL: if (done) begin
        st_nx  = ST_WDRIVE;
        ld     = 1'b1;
        ld_val = CNT_W'(DRV_CYC - 1);
      end
      ST_WDRIVE: if (done) begin
        st_nx = ST_WHOLD;
        ld    = 1'b1;
      end
      ST_WHOLD: if (done) begin
        st_nx  = ST_IDLE;
        fin_wr = 1'b1;
      end
      ST_RACC: if (done) begin
        st_nx  = ST_IDLE;
        fin_rd = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      st       <= st_nx;
      host_ack <= fin_rd | fin_wr;
      if (fin_rd)
        host_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_seq_checker.sv
module sram_seq_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ack,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  assert_no_fight_R8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  assert_we_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  assert_drive_after_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  assert_ack_idle_R10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (mem_ce_n && !mem_dq_oe));
endmodule

bind sram_seq_ctrl sram_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  // Bench-side cycle counts: smallest n >= 1 with n*period >= time.
  function automatic int need(input int t, input int p);
    int n;
    n = 1;
    while (n * p < t) n++;
    return n;
  endfunction

  localparam int PER = 10000;
  localparam int B_RD  = need(12000, PER);
  localparam int B_WP  = need(10000, PER);
  localparam int B_DS  = need(6000, PER);
  localparam int B_REL = need(6000, PER);
  localparam int B_TA  = need(5000, PER);
  localparam int B_DRV = (B_DS > B_WP - B_REL) ? B_DS : (B_WP - B_REL);

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Memory stand-in on the pins.
  logic [7:0] sram [int];
  int sram_tick = 0;
  always @(posedge mem_we_n) begin
    if (!rst && mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
      sram[int'(mem_addr)] = mem_dq_out;
      sram_tick++;
    end
  end
  always @(mem_ce_n, mem_oe_n, mem_we_n, mem_addr, sram_tick) begin
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
      mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'h00;
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: a queue of expected future cycles.
  typedef struct {
    bit ce, oe, we, dq, ack, rd;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;
  logic [7:0] ref_mem [int];
  bit   have_prev = 0, prev_wr = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rexp = '0;
  int acks_exp = 0, acks_seen = 0;

  function automatic exp_t mk(input bit ce, oe, we, dq, ack, rd, input string tag);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.dq = dq; e.ack = ack; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = mk(1, 1, 1, 0, 0, 0, "R1");
      have_prev = 0;
    end else begin
      if (q.size() == 0 && host_req) begin
        if (have_prev && prev_wr != host_wr)
          for (int i = 0; i < B_TA; i++) q.push_back(mk(1, 1, 1, 0, 0, 0, "R7"));
        m_addr = host_addr;
        if (host_wr) begin
          m_wdata = host_wdata;
          ref_mem[int'(host_addr)] = host_wdata;
          q.push_back(mk(0, 1, 1, 0, 0, 0, "R4"));
          for (int i = 0; i < B_REL; i++) q.push_back(mk(0, 1, 0, 0, 0, 0, "R5"));
          for (int i = 0; i < B_DRV; i++) q.push_back(mk(0, 1, 0, 1, 0, 0, "R5"));
          q.push_back(mk(0, 1, 1, 1, 0, 0, "R5"));
          q.push_back(mk(1, 1, 1, 0, 1, 0, "R10"));
        end else begin
          m_rexp = ref_mem.exists(int'(host_addr)) ? ref_mem[int'(host_addr)] : 8'h00;
          for (int i = 0; i < B_RD; i++) q.push_back(mk(0, 0, 1, 0, 0, 0, "R3"));
          q.push_back(mk(1, 1, 1, 0, 1, 1, "R3"));
        end
        have_prev = 1;
        prev_wr = host_wr;
        acks_exp++;
      end
      cur = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 0, 0, 0, "R2");
    end
  end

  // Compare on every clock, away from the active edge. R9 is covered by the
  // model ignoring requests while its queue is busy.
  always @(negedge clk) begin
    if (!rst) begin
      chk(mem_ce_n == !cur.ce ? 1'b0 : 1'b1, cur.tag, "ce_n", int'(mem_ce_n), int'(cur.ce));
      chk(mem_oe_n == cur.oe, cur.tag, "oe_n", int'(mem_oe_n), int'(cur.oe));
      chk(mem_we_n == cur.we, cur.tag, "we_n", int'(mem_we_n), int'(cur.we));
      chk(mem_dq_oe == cur.dq, cur.tag, "dq_oe", int'(mem_dq_oe), int'(cur.dq));
      chk(host_ack == cur.ack, "R10", "host_ack", int'(host_ack), int'(cur.ack));
      chk(!(mem_dq_oe && !mem_oe_n), "R8", "drive during read", int'(mem_dq_oe), 0);
      if (!cur.ce) chk(mem_addr == m_addr, "R6", "mem_addr", int'(mem_addr), int'(m_addr));
      if (cur.dq) chk(mem_dq_out == m_wdata, "R5", "mem_dq_out", int'(mem_dq_out), int'(m_wdata));
      if (cur.rd) chk(host_rdata == m_rexp, "R3", "host_rdata", int'(host_rdata), int'(m_rexp));
      if (host_ack) acks_seen++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic txn(input bit wr, input logic [14:0] a, input logic [7:0] d,
                     input bit meddle);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    if (meddle) begin
      // R9: rewrite every host input while the access is in flight.
      @(negedge clk); @(negedge clk);
      host_wr = ~wr; host_addr = ~a; host_wdata = ~d;
    end
    do @(negedge clk); while (!host_ack);
    host_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values seen while reset is high.
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && !host_ack, "R1", "dq_oe/ack in reset",
        int'({mem_dq_oe, host_ack}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    txn(1, 15'h0001, 8'h5A, 0);
    txn(1, 15'h7FFF, 8'hA5, 0);
    txn(0, 15'h0001, 8'h00, 0);   // R7 turn
    txn(0, 15'h7FFF, 8'h00, 0);
    txn(0, 15'h1234, 8'h00, 0);   // unwritten location
    txn(1, 15'h1234, 8'h3C, 0);
    txn(0, 15'h1234, 8'h00, 0);
    txn(1, 15'h0042, 8'h99, 1);   // R9 busy-time changes
    txn(0, 15'h0042, 8'h00, 1);
    for (int n = 0; n < 60; n++) begin
      txn(1'($urandom_range(0, 1)), 15'($urandom_range(0, 7)),
          8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(acks_seen == acks_exp, "R9", "ack count", acks_seen, acks_exp);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule